// File: doc/BRIEF.md
# Instruction Address Sequencer with Trap Entry

This block keeps the address of the instruction now retiring and the address of the one after it for a 64-bit core. Each retirement moves the sequencer forward. It either steps to the next sequential word (four bytes on) or jumps to a branch target that the execute stage supplies. The two addresses always stay exactly one instruction word apart.

When a retiring instruction is illegal, or when the execute stage raises a trap request, the sequencer enters the trap vector in place of the normal next address. On entry it does three things:
- it copies the address of the faulting instruction into one save register;
- it copies the machine state word, as it was before the trap, into a second save register;
- it sets one cause bit in the machine state word.

Cause bits are counted from the most significant end. An attention (halt) instruction freezes the sequencer until reset. Trap return and full exception ranking belong to other blocks.

Top module: `pc_trap_seq`

## Requirements
- R1: While rst_n is low and after it rises (before any retirement), cia equals boot_addr, nia equals boot_addr + 4, msr equals the MSR_RST parameter (default 0), srr0 and srr1 are zero, and halted is 0.
- R2: A retirement with no branch, trap, illegal or halt makes cia take the old nia and nia the new cia + 4 on the same clock edge, with addresses wrapping modulo 2^64.
- R3: A retirement with br_taken high makes cia equal br_target and nia equal br_target + 4.
- R4: In a cycle where retire_vld is low, every output keeps its value.
- R5: A retirement with trap_req high saves the pre-trap cia into srr0 and the pre-trap msr (without the new cause bit) into srr1. It ORs into msr a single 1 at bit (63 − trap_cause), so cause 0 is bit 63 and cause 63 is bit 0. It makes cia equal TRAP_VEC (default 0x700) and nia equal TRAP_VEC + 4.
- R6: A retirement with illegal_op high and cr_move low takes the trap of R5 with the cause index ILL_CAUSE (default 19, so msr bit 44), whatever trap_cause holds.
- R7: When cr_move is high, illegal_op is ignored: the retirement advances or branches as in R2 or R3.
- R8: Within one retirement, halt wins over an illegal instruction, an illegal instruction wins over trap_req (the cause is ILL_CAUSE), and any trap wins over br_taken.
- R9: A retirement with halt_req high sets halted and leaves cia, nia, srr0, srr1 and msr unchanged.
- R10: Once halted is 1, it stays 1 and every later retirement is ignored until rst_n goes low.
- R11: Trap entry never clears msr bits, so cause bits from successive traps accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_addr | input | 64 | Start address loaded during reset |
| retire_vld | input | 1 | An instruction retires this cycle |
| br_taken | input | 1 | Retiring instruction redirects to br_target |
| br_target | input | 64 | Branch destination |
| illegal_op | input | 1 | Decoded name did not match the opcode |
| cr_move | input | 1 | Retiring instruction is a condition-field move, exempt from the illegal check |
| trap_req | input | 1 | Retiring instruction requests a trap |
| trap_cause | input | 6 | Cause bit index for trap_req, most significant bit counted as 0 |
| halt_req | input | 1 | Retiring instruction is an attention/halt |
| cia | output | 64 | Current instruction address |
| nia | output | 64 | Next instruction address |
| srr0 | output | 64 | Saved address of the trapping instruction |
| srr1 | output | 64 | Saved pre-trap machine state |
| msr | output | 64 | Machine state word |
| halted | output | 1 | Sequencer frozen by halt |

## Verification
Every output is a register written on the clock edge that samples the retirement. The effect of a stimulus is therefore due at exactly one edge later. The driver applies each retirement at a falling edge and at the same moment queues the state that the requirements predict. The monitor takes one queued item one nanosecond after each rising edge and compares all six outputs, so a result that comes early or late is caught at its own edge. The reset state is checked on its own before the first rising edge after release.

// File: rtl/pc_trap_seq.sv
module pc_trap_seq #(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] TRAP_VEC  = 'h700,
  parameter int              ILL_CAUSE = 19,
  parameter logic [XLEN-1:0] MSR_RST   = '0,
  localparam int             CW        = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] boot_addr,
  input  logic            retire_vld,
  input  logic            br_taken,
  input  logic [XLEN-1:0] br_target,
  input  logic            illegal_op,
  input  logic            cr_move,
  input  logic            trap_req,
  input  logic [CW-1:0]   trap_cause,
  input  logic            halt_req,
  output logic [XLEN-1:0] cia,
  output logic [XLEN-1:0] nia,
  output logic [XLEN-1:0] srr0,
  output logic [XLEN-1:0] srr1,
  output logic [XLEN-1:0] msr,
  output logic            halted
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic            live, go, ill_hit, trap_hit;
  logic [CW-1:0]   cause;
  logic [XLEN-1:0] cause_mask, next_pc;

  assign live       = retire_vld & ~halted;
  assign go         = live & ~halt_req;
  assign ill_hit    = go & illegal_op & ~cr_move;
  assign trap_hit   = ill_hit | (go & trap_req);
  assign cause      = ill_hit ? CW'(ILL_CAUSE) : trap_cause;
  assign cause_mask = {{(XLEN-1){1'b0}}, 1'b1} << (CW'(XLEN-1) - cause);
  assign next_pc    = trap_hit ? TRAP_VEC : (br_taken ? br_target : nia);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cia    <= boot_addr;
      nia    <= boot_addr + STEP;
      srr0   <= '0;
      srr1   <= '0;
      msr    <= MSR_RST;
      halted <= 1'b0;
    end else begin
      if (go) begin
        cia <= next_pc;
        nia <= next_pc + STEP;
      end
      if (trap_hit) begin
        srr0 <= cia;
        srr1 <= msr;
        msr  <= msr | cause_mask;
      end
      if (live & halt_req) halted <= 1'b1;
    end
  end

  // R2 R3 R5
  nia_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nia == cia + STEP);

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R9 R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted | (retire_vld & halt_req)) |=> ($stable(cia) && $stable(msr) && $stable(srr0)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_vld |=> ($stable(cia) && $stable(srr1) && $stable(msr)));

  // R5 R6
  trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld & !halted & !halt_req & (trap_req | (illegal_op & !cr_move)))
      |=> (cia == TRAP_VEC && srr0 == $past(cia) && srr1 == $past(msr)
           && $countones(msr ^ $past(msr)) <= 1));

  // R11
  msr_accum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((msr & $past(msr)) == $past(msr)));

endmodule

// File: tb/pc_trap_seq_tb_top.sv
`timescale 1ns/1ps
module pc_trap_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] boot_addr = 64'h1000;
  logic        retire_vld = 0, br_taken = 0, illegal_op = 0, cr_move = 0;
  logic        trap_req = 0, halt_req = 0;
  logic [63:0] br_target = '0;
  logic [5:0]  trap_cause = '0;
  logic [63:0] cia, nia, srr0, srr1, msr;
  logic        halted;

  always #2.5 clk = ~clk;

  pc_trap_seq dut_i (
    .clk(clk), .rst_n(rst_n), .boot_addr(boot_addr), .retire_vld(retire_vld),
    .br_taken(br_taken), .br_target(br_target), .illegal_op(illegal_op),
    .cr_move(cr_move), .trap_req(trap_req), .trap_cause(trap_cause),
    .halt_req(halt_req), .cia(cia), .nia(nia), .srr0(srr0), .srr1(srr1),
    .msr(msr), .halted(halted));

  typedef struct packed {
    logic [63:0] cia, nia, srr0, srr1, msr;
    logic        hlt;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0, errors = 0;
  bit    done = 0;

  logic [63:0] m_cia, m_nia, m_srr0, m_srr1, m_msr;
  logic        m_hlt;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset(logic [63:0] b);
    m_cia = b; m_nia = b + 64'd4; m_srr0 = '0; m_srr1 = '0; m_msr = '0; m_hlt = 0;
  endtask

  task automatic check_now(string tag);
    chk(tag, "cia", cia, m_cia);
    chk(tag, "nia", nia, m_nia);
    chk(tag, "srr0", srr0, m_srr0);
    chk(tag, "srr1", srr1, m_srr1);
    chk(tag, "msr", msr, m_msr);
    chk(tag, "halted", {63'd0, halted}, {63'd0, m_hlt});
  endtask

  task automatic op(string tag, bit v, bit br, logic [63:0] tgt, bit il, bit ex,
                    bit tp, logic [5:0] cs, bit hl);
    logic [63:0] nxt;
    int c;
    bit ill, tr;
    @(negedge clk);
    retire_vld = v; br_taken = br; br_target = tgt; illegal_op = il;
    cr_move = ex; trap_req = tp; trap_cause = cs; halt_req = hl;
    if (v && !m_hlt) begin
      if (hl) m_hlt = 1;
      else begin
        ill = il && !ex;
        tr  = ill || tp;
        c   = ill ? 19 : int'(cs);
        if (tr) begin
          m_srr0 = m_cia; m_srr1 = m_msr;
          m_msr  = m_msr | (64'd1 << (63 - c));
          nxt    = 64'h700;
        end else if (br) nxt = tgt;
        else nxt = m_nia;
        m_cia = nxt; m_nia = nxt + 64'd4;
      end
    end
    exp_q.push_back({m_cia, m_nia, m_srr0, m_srr1, m_msr, m_hlt});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, "cia", cia, e.cia);
      chk(t, "nia", nia, e.nia);
      chk(t, "srr0", srr0, e.srr0);
      chk(t, "srr1", srr1, e.srr1);
      chk(t, "msr", msr, e.msr);
      chk(t, "halted", {63'd0, halted}, {63'd0, e.hlt});
    end
  end

  task automatic drain;
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic do_reset(logic [63:0] b);
    @(negedge clk);
    retire_vld = 0;
    rst_n = 0; boot_addr = b;
    model_reset(b);
    repeat (2) @(negedge clk);
    check_now("R1 in reset");
    rst_n = 1;
    #0.1;
    check_now("R1 after release");
  endtask

  initial begin
    model_reset(64'h1000);
    do_reset(64'h1000);
    op("R2 step", 1,0,0,0,0,0,0,0);
    op("R2 step", 1,0,0,0,0,0,0,0);
    op("R4 idle", 0,1,64'h55,1,0,1,6'd3,1);
    op("R3 branch", 1,1,64'h8000,0,0,0,0,0);
    op("R2 after branch", 1,0,0,0,0,0,0,0);
    op("R3 branch to top", 1,1,64'hFFFF_FFFF_FFFF_FFFC,0,0,0,0,0);
    op("R2 wrap", 1,0,0,0,0,0,0,0);
    op("R5 trap cause 0", 1,0,0,0,0,1,6'd0,0);
    op("R2 at vector", 1,0,0,0,0,0,0,0);
    op("R5 R11 trap cause 63", 1,0,0,0,0,1,6'd63,0);
    op("R6 illegal", 1,0,0,1,0,0,6'd5,0);
    op("R7 exempt step", 1,0,0,1,1,0,0,0);
    op("R7 exempt branch", 1,1,64'h2468,1,1,0,0,0);
    op("R8 illegal over trap", 1,1,64'h9990,1,0,1,6'd10,0);
    op("R8 trap over branch", 1,1,64'h4440,0,0,1,6'd32,0);
    op("R11 repeat cause", 1,0,0,0,0,1,6'd32,0);
    op("R8 R9 halt wins", 1,1,64'h1230,1,0,1,6'd7,1);
    op("R10 ignored step", 1,0,0,0,0,0,0,0);
    op("R10 ignored trap", 1,1,64'h50,1,0,1,6'd1,0);
    op("R10 idle", 0,0,0,0,0,0,0,0);
    drain();
    do_reset(64'hABCD_0000_0000_0040);
    op("R2 after reset", 1,0,0,0,0,0,0,0);
    op("R5 fresh msr", 1,0,0,0,0,1,6'd62,0);
    op("R4 idle end", 0,0,0,0,0,0,0,0);
    drain();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule